// File: doc/BRIEF.md
# SMBus Host Controller Register Front-End

This block is the byte-wide register face of an SMBus host controller. Software programs a slave address with a direction bit, a command byte, two data bytes and an optional block of up to 32 bytes. It then writes the control register with the start bit set. The block checks the requested protocol and latches the transfer kind and direction. It then holds one abstract transaction request toward a downstream bus engine until that engine responds.

On the response, read data is written back into the data registers, and status reports whether the transfer finished cleanly or was refused by the device. Block transfers go through a 32-byte buffer. Software reaches it through a single port that advances an internal index on every access. The engine reaches it through its own pointer. No SCL or SDA signalling is produced here.

Top module: `smb_host_front`

## Requirements
- R1: After reset every readable register returns 0x00 and no request is pending.
- R2: Registers sit at offsets status 0, control 2, command 3, address 4, data-low 5, data-high 6 and block port 7. Control keeps only bits 4:0, and a control read returns 0 in bits 7:5.
- R3: Writing control with bit 6 set while idle, with a legal kind in bits 4:2, raises `reqValid` and status bit 0 (busy) one cycle later. `reqKind` = bits 4:2, `reqRead` = address bit 0, and `reqSlave` = address bits 7:1. The legal kinds are 0 quick, 1 byte, 2 byte-with-command, 3 word and 5 block.
- R4: A `rspValid` during a request ends it. On the next cycle busy and `reqValid` are low and status bit 1 (done) is set.
- R5: On a read response, byte kinds store `rspData0` into data-low. The word kind stores `rspData0` into data-low and `rspData1` into data-high. Write transfers change neither register.
- R6: `reqData` presents {data-high, data-low}. For a block write, data-low is the byte count.
- R7: During a block read the engine fills the buffer through `engWrEn`/`engPtr`, and the response's `rspData0` (the count) lands in data-low.
- R8: Each block-port read or write uses buffer[index] and then advances the index. The index returns to 0 after entry 31.
- R9: Reading the control register sets the block index to 0.
- R10: A start with kind 4, 6 or 7 sets status bit 3 (failed) and raises no request.
- R11: Status bits 3:1 clear when 1 is written to them. Writing 0 keeps them, and the busy bit is not writable.
- R12: While busy, writes to every register other than status are dropped, and so is a further start.
- R13: A response with `rspErr` set clears busy and sets status bit 2 (device error). Done stays clear and no data is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Register offset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (for side effects) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `regSel` |
| reqValid | output | 1 | Transaction request pending |
| reqKind | output | 3 | Transfer kind |
| reqRead | output | 1 | 1 = read transfer |
| reqSlave | output | 7 | 7-bit slave address |
| reqCmd | output | 8 | Command byte |
| reqData | output | 16 | {data-high, data-low} |
| rspValid | input | 1 | Engine response strobe |
| rspErr | input | 1 | Device refused the transfer |
| rspData0 | input | 8 | Returned low byte or block count |
| rspData1 | input | 8 | Returned high byte |
| engWrEn | input | 1 | Engine buffer write |
| engPtr | input | 5 | Engine buffer pointer |
| engWrData | input | 8 | Engine buffer write data |
| engRdData | output | 8 | Buffer byte at `engPtr` |

## Verification
The bench wraps the block index with 33 writes. A design that wraps one entry late, or never wraps, shows a stale byte at entry 0 after a control read. Word reads are checked byte by byte, so swapped halves show up at once. A byte read is checked to leave data-high alone. A start or a command write is issued mid-transfer to catch a controller that relaunches or lets request fields drift. Illegal kinds and refused responses are checked to set only their own status bit and never done.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam logic [2:0] OFS_STAT = 3'd0;
  localparam logic [2:0] OFS_CTL  = 3'd2;
  localparam logic [2:0] OFS_CMD  = 3'd3;
  localparam logic [2:0] OFS_ADDR = 3'd4;
  localparam logic [2:0] OFS_D0   = 3'd5;
  localparam logic [2:0] OFS_D1   = 3'd6;
  localparam logic [2:0] OFS_BLK  = 3'd7;

  localparam int START_BIT = 6;

  typedef enum logic [2:0] {
    K_QUICK = 3'd0,
    K_BYTE  = 3'd1,
    K_BDATA = 3'd2,
    K_WDATA = 3'd3,
    K_BLOCK = 3'd5
  } kindT;

  typedef struct packed {
    logic capD0;
    logic capD1;
    logic hostBusy;
  } strobeT;

  function automatic logic kindLegal(input logic [2:0] k);
    return (k == K_QUICK) || (k == K_BYTE) || (k == K_BDATA) ||
           (k == K_WDATA) || (k == K_BLOCK);
  endfunction
endpackage

// File: rtl/smb_host_ctrl.sv
module smb_host_ctrl
  import smb_host_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regSel,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       addrRead,
  input  logic       rspValid,
  input  logic       rspErr,
  output logic [7:0] statusByte,
  output logic       reqValid,
  output logic [2:0] reqKind,
  output logic       reqRead,
  output strobeT     strobes
);
  logic       busy, doneQ, devErrQ, failQ;
  logic [2:0] kindQ;
  logic       readQ;
  logic       startHit, statWr, rspHit, okRead;

  assign startHit = wrEn && (regSel == OFS_CTL) && !busy && wrData[START_BIT];
  assign statWr   = wrEn && (regSel == OFS_STAT);
  assign rspHit   = busy && rspValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      doneQ   <= 1'b0;
      devErrQ <= 1'b0;
      failQ   <= 1'b0;
      kindQ   <= 3'd0;
      readQ   <= 1'b0;
    end else begin
      if (statWr) begin
        if (wrData[1]) doneQ   <= 1'b0;
        if (wrData[2]) devErrQ <= 1'b0;
        if (wrData[3]) failQ   <= 1'b0;
      end
      if (startHit) begin
        if (kindLegal(wrData[4:2])) begin
          busy  <= 1'b1;
          kindQ <= wrData[4:2];
          readQ <= addrRead;
        end else begin
          failQ <= 1'b1;
        end
      end
      if (rspHit) begin
        busy <= 1'b0;
        if (rspErr) devErrQ <= 1'b1;
        else        doneQ   <= 1'b1;
      end
    end
  end

  assign okRead = rspHit && !rspErr && readQ;

  always_comb begin
    strobes.hostBusy = busy;
    strobes.capD0    = okRead && (kindQ != K_QUICK);
    strobes.capD1    = okRead && (kindQ == K_WDATA);
  end

  assign statusByte = {4'b0, failQ, devErrQ, doneQ, busy};
  assign reqValid   = busy;
  assign reqKind    = kindQ;
  assign reqRead    = readQ;
endmodule

// File: rtl/smb_host_dpath.sv
module smb_host_dpath
  import smb_host_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [7:0]       wrData,
  input  strobeT           strobes,
  input  logic [7:0]       statusByte,
  input  logic [7:0]       rspData0,
  input  logic [7:0]       rspData1,
  input  logic             engWrEn,
  input  logic [IDX_W-1:0] engPtr,
  input  logic [7:0]       engWrData,
  output logic [7:0]       engRdData,
  output logic [7:0]       rdData,
  output logic             addrRead,
  output logic [6:0]       reqSlave,
  output logic [7:0]       reqCmd,
  output logic [15:0]      reqData
);
  logic [4:0]       ctlQ;
  logic [7:0]       cmdQ, addrQ, d0Q, d1Q;
  logic [IDX_W-1:0] idxQ, idxNext;
  logic [7:0]       mem [DEPTH];
  logic             hostWr, blkTouch, engWrOk;

  assign hostWr   = wrEn && !strobes.hostBusy;
  assign blkTouch = (regSel == OFS_BLK) && (rdEn || hostWr);
  assign engWrOk  = engWrEn && strobes.hostBusy;
  assign idxNext  = (idxQ == IDX_W'(DEPTH - 1)) ? '0 : idxQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ  <= '0;
      cmdQ  <= '0;
      addrQ <= '0;
      d0Q   <= '0;
      d1Q   <= '0;
      idxQ  <= '0;
    end else begin
      if (hostWr) begin
        case (regSel)
          OFS_CTL:  ctlQ  <= wrData[4:0];
          OFS_CMD:  cmdQ  <= wrData;
          OFS_ADDR: addrQ <= wrData;
          OFS_D0:   d0Q   <= wrData;
          OFS_D1:   d1Q   <= wrData;
          default:  ;
        endcase
      end
      if (strobes.capD0) d0Q <= rspData0;
      if (strobes.capD1) d1Q <= rspData1;
      if (rdEn && (regSel == OFS_CTL)) idxQ <= '0;
      else if (blkTouch)               idxQ <= idxNext;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hostHit, engHit;
    assign hostHit = hostWr && (regSel == OFS_BLK) && (idxQ == IDX_W'(e));
    assign engHit  = engWrOk && (engPtr == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rstN)        mem[e] <= '0;
      else if (engHit)  mem[e] <= engWrData;
      else if (hostHit) mem[e] <= wrData;
    end
  end

  always_comb begin
    case (regSel)
      OFS_STAT: rdData = statusByte;
      OFS_CTL:  rdData = {3'b0, ctlQ};
      OFS_CMD:  rdData = cmdQ;
      OFS_ADDR: rdData = addrQ;
      OFS_D0:   rdData = d0Q;
      OFS_D1:   rdData = d1Q;
      OFS_BLK:  rdData = mem[idxQ];
      default:  rdData = 8'h00;
    endcase
  end

  assign engRdData = mem[engPtr];
  assign addrRead  = addrQ[0];
  assign reqSlave  = addrQ[7:1];
  assign reqCmd    = cmdQ;
  assign reqData   = {d1Q, d0Q};
endmodule

// File: rtl/smb_host_front.sv
module smb_host_front
  import smb_host_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regSel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        reqValid,
  output logic [2:0]  reqKind,
  output logic        reqRead,
  output logic [6:0]  reqSlave,
  output logic [7:0]  reqCmd,
  output logic [15:0] reqData,
  input  logic        rspValid,
  input  logic        rspErr,
  input  logic [7:0]  rspData0,
  input  logic [7:0]  rspData1,
  input  logic        engWrEn,
  input  logic [4:0]  engPtr,
  input  logic [7:0]  engWrData,
  output logic [7:0]  engRdData
);
  strobeT     strobes;
  logic [7:0] statusByte;
  logic       addrRead;

  smb_host_ctrl ctrl_i (
    .clk, .rstN, .regSel, .wrEn, .wrData, .addrRead,
    .rspValid, .rspErr, .statusByte, .reqValid, .reqKind, .reqRead,
    .strobes
  );

  smb_host_dpath #(.DEPTH(32)) dpath_i (
    .clk, .rstN, .regSel, .wrEn, .rdEn, .wrData, .strobes, .statusByte,
    .rspData0, .rspData1, .engWrEn, .engPtr, .engWrData, .engRdData,
    .rdData, .addrRead, .reqSlave, .reqCmd, .reqData
  );
endmodule

// File: rtl/smb_host_front_chk.sv
module smb_host_front_chk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  regSel,
  input logic        wrEn,
  input logic        rdEn,
  input logic [7:0]  wrData,
  input logic [7:0]  rdData,
  input logic        reqValid,
  input logic [2:0]  reqKind,
  input logic [6:0]  reqSlave,
  input logic [7:0]  reqCmd,
  input logic [15:0] reqData,
  input logic        rspValid
);
  logic startIdle, kindOk;
  assign startIdle = wrEn && (regSel == 3'd2) && wrData[6] && !reqValid;
  assign kindOk    = (wrData[4:2] <= 3'd3) || (wrData[4:2] == 3'd5);

  AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == 3'd2) |-> (rdData[7:5] == 3'b000)); // R2
  AST_LAUNCH_KIND: assert property (@(posedge clk) disable iff (!rstN)
    (startIdle && kindOk) |=> (reqValid && reqKind == $past(wrData[4:2]))); // R3
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqKind <= 3'd3 || reqKind == 3'd5)); // R3
  AST_RSP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && rspValid) |=> !reqValid); // R4
  AST_BAD_KIND_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (startIdle && !kindOk) |=> !reqValid); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !rspValid) |=> (reqValid && $stable(reqCmd) &&
      $stable(reqSlave) && $stable(reqKind) && $stable(reqData))); // R12
endmodule

bind smb_host_front smb_host_front_chk chk_i (
  .clk, .rstN, .regSel, .wrEn, .rdEn, .wrData, .rdData, .reqValid,
  .reqKind, .reqSlave, .reqCmd, .reqData, .rspValid
);

// File: tb/smb_host_front_tb_top.sv
module smb_host_front_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regSel = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        reqValid, reqRead;
  logic [2:0]  reqKind;
  logic [6:0]  reqSlave;
  logic [7:0]  reqCmd;
  logic [15:0] reqData;
  logic        rspValid = 1'b0, rspErr = 1'b0;
  logic [7:0]  rspData0 = '0, rspData1 = '0;
  logic        engWrEn = 1'b0;
  logic [4:0]  engPtr = '0;
  logic [7:0]  engWrData = '0;
  logic [7:0]  engRdData;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  smb_host_front dut_i (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] v);
    @(negedge clk);
    regSel = sel; wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [7:0] v);
    @(negedge clk);
    regSel = sel; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic respond(input logic [7:0] a, input logic [7:0] b, input logic e);
    @(negedge clk);
    rspValid = 1'b1; rspData0 = a; rspData1 = b; rspErr = e;
    @(negedge clk);
    rspValid = 1'b0; rspErr = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int s = 0; s < 7; s++) begin
      rd(3'(s), v);
      chk("R1 reset register", {8'h0, v}, 16'h0);
    end
    chk("R1 no request", {15'h0, reqValid}, 16'h0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd3, 8'h5A); rd(3'd3, v); chk("R2 command", {8'h0, v}, 16'h5A);
    wr(3'd6, 8'hC3); rd(3'd6, v); chk("R2 data-high", {8'h0, v}, 16'hC3);
    wr(3'd2, 8'hBF); rd(3'd2, v); chk("R2 control masked", {8'h0, v}, 16'h1F);
    chk("R2 no start on bit6 clear", {15'h0, reqValid}, 16'h0);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_word_write();
    logic [7:0] v;
    wr(3'd4, 8'hA4); wr(3'd3, 8'h11); wr(3'd5, 8'h34); wr(3'd6, 8'h12);
    wr(3'd2, 8'h4C);
    chk("R3 request raised", {15'h0, reqValid}, 16'h1);
    chk("R3 kind", {13'h0, reqKind}, 16'h3);
    chk("R3 direction", {15'h0, reqRead}, 16'h0);
    chk("R3 slave", {9'h0, reqSlave}, 16'h52);
    chk("R3 command", {8'h0, reqCmd}, 16'h11);
    chk("R6 word data", reqData, 16'h1234);
    rd(3'd0, v); chk("R3 busy", {8'h0, v}, 16'h01);
    respond(8'hEE, 8'hEE, 1'b0);
    chk("R4 request dropped", {15'h0, reqValid}, 16'h0);
    rd(3'd0, v); chk("R4 done only", {8'h0, v}, 16'h02);
    chk("R5 write leaves data", reqData, 16'h1234);
    wr(3'd0, 8'h00); rd(3'd0, v); chk("R11 zero write keeps", {8'h0, v}, 16'h02);
    wr(3'd0, 8'h02); rd(3'd0, v); chk("R11 done cleared", {8'h0, v}, 16'h00);
  endtask

  task automatic t_reads();
    logic [7:0] v;
    wr(3'd4, 8'hA5); wr(3'd2, 8'h4C);
    chk("R3 read direction", {15'h0, reqRead}, 16'h1);
    respond(8'hCD, 8'hAB, 1'b0);
    chk("R5 word read order", reqData, 16'hABCD);
    wr(3'd0, 8'h02);
    wr(3'd2, 8'h44);
    respond(8'h77, 8'h99, 1'b0);
    chk("R5 byte read keeps high", reqData, 16'hAB77);
    wr(3'd0, 8'h02);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    wr(3'd3, 8'h21); wr(3'd2, 8'h48);
    wr(3'd3, 8'h77);
    chk("R12 command held", {8'h0, reqCmd}, 16'h21);
    wr(3'd2, 8'h54);
    chk("R12 restart ignored", {13'h0, reqKind}, 16'h2);
    respond(8'h10, 8'h00, 1'b0);
    rd(3'd3, v); chk("R12 command unchanged", {8'h0, v}, 16'h21);
    rd(3'd2, v); chk("R12 control unchanged", {8'h0, v}, 16'h08);
    wr(3'd0, 8'h0E);
  endtask

  task automatic t_bad();
    logic [7:0] v;
    logic [2:0] bad [3] = '{3'd4, 3'd6, 3'd7};
    for (int i = 0; i < 3; i++) begin
      wr(3'd2, {2'b01, 1'b0, bad[i], 2'b00});
      chk("R10 no request", {15'h0, reqValid}, 16'h0);
      rd(3'd0, v); chk("R10 failed bit", {8'h0, v}, 16'h08);
      wr(3'd0, 8'h01); rd(3'd0, v); chk("R11 busy not writable", {8'h0, v}, 16'h08);
      wr(3'd0, 8'h08);
    end
  endtask

  task automatic t_err();
    logic [7:0] v;
    wr(3'd5, 8'h3C); wr(3'd4, 8'hA5); wr(3'd2, 8'h48);
    respond(8'h99, 8'h88, 1'b1);
    rd(3'd0, v); chk("R13 device error only", {8'h0, v}, 16'h04);
    rd(3'd5, v); chk("R13 no capture", {8'h0, v}, 16'h3C);
    wr(3'd0, 8'h04);
  endtask

  task automatic t_block_read();
    logic [7:0] v;
    wr(3'd4, 8'hA5); wr(3'd2, 8'h54);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      engWrEn = 1'b1; engPtr = 5'(i); engWrData = 8'hD0 + 8'(i);
    end
    @(negedge clk); engWrEn = 1'b0;
    respond(8'h03, 8'h00, 1'b0);
    rd(3'd5, v); chk("R7 count in data-low", {8'h0, v}, 16'h03);
    rd(3'd2, v);
    for (int i = 0; i < 3; i++) begin
      rd(3'd7, v); chk("R7 block byte", {8'h0, v}, 16'hD0 + 16'(i));
    end
    wr(3'd0, 8'h02);
  endtask

  task automatic t_block_write();
    logic [7:0] v;
    rd(3'd2, v);
    for (int i = 0; i < 33; i++) wr(3'd7, 8'h80 + 8'(i));
    wr(3'd5, 8'h05);
    rd(3'd2, v);
    rd(3'd7, v); chk("R8 wrap overwrote entry 0", {8'h0, v}, 16'hA0);
    rd(3'd7, v); chk("R9 index restarted", {8'h0, v}, 16'h81);
    wr(3'd4, 8'hA4); wr(3'd2, 8'h54);
    chk("R6 block length", {8'h0, reqData[7:0]}, 16'h05);
    @(negedge clk); engPtr = 5'd2;
    #1 chk("R7 engine read", {8'h0, engRdData}, 16'h82);
    respond(8'hFF, 8'hFF, 1'b0);
    rd(3'd5, v); chk("R5 block write keeps count", {8'h0, v}, 16'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_word_write();
    t_reads();
    t_busy();
    t_bad();
    t_err();
    t_block_read();
    t_block_write();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule